// File: doc/BRIEF.md
# Triggered DAC sample FIFO controller

This block sits in front of a multi-channel 12-bit analogue output. A 16-bit host bus programs a control/status register and a channel-enable mask, and it pushes samples into a 1024-entry FIFO through a data port. Each scan trigger takes one sample per enabled channel from the FIFO, in ascending channel order, and loads it into that channel's output register. One channel is handled per clock. The trigger comes from one of several sources: a host read, a rising or falling edge on an external pin, or the rising edge of one of three timer outputs. Edges on the pin and timer inputs are detected after a two-flop synchronizer.

The FIFO path works only when the global allow input is high and the FIFO enable bit is set. Otherwise the block runs in direct mode, and host writes to per-channel output registers take effect on the next clock. A level interrupt follows a FIFO-level condition chosen by a register field. A scan that runs out of samples sets a sticky underrun flag. In wraparound mode each popped sample goes back into the FIFO, so the loaded pattern repeats.

The data port uses a ready handshake. A data-port write counts only in a cycle where `host_wr_ready` is high. `host_wr_ready` drops when the FIFO is full, and also in any cycle where wraparound is re-queuing a sample. A write made while ready is low is dropped, and the host must repeat it. Control and status pins are plain levels.

Top module: `dac_scan_fifo`

Register addresses (word index on `host_addr`) and control bit positions:

| Address | Write action | Read returns |
|---|---|---|
| 0 | control fields | status word |
| 1 | push a sample | 0, and gives a software trigger |
| 2 | channel-enable mask | channel-enable mask |
| 3 + n | direct output for channel n | output of channel n in bits 15:4 |

| Control bit | Meaning |
|---|---|
| 0 | range select, read/write |
| 1 | busy, read only |
| 4:2 | trigger source, read/write |
| 5 | underrun; read gives the latch, writing 1 clears it |
| 7 | wraparound, read/write |
| 8 | FIFO enable, read/write |
| 11:9 | interrupt condition, read/write |
| 12 | writing 1 resets the FIFO; always reads 0 |
| 13 | FIFO empty, read only |
| 14 | FIFO full, read only |
| 15 | FIFO half full, read only |

## Requirements
- R1: After reset the control address reads 16'h2000 (only empty set), every channel output is 0, `irq` is 0 and `bipolar` is 0.
- R2: FIFO mode is active only when `fifo_allow` is high and control bit 8 is 1. Outside FIFO mode, a write to address 3+n loads wdata[15:4] into channel n on the next clock, and data-port writes are not stored. In FIFO mode, direct-output writes are ignored.
- R3: A data-port write that is accepted stores wdata[15:4] and ignores bits 3:0. The FIFO holds up to 1024 samples. Bit 13 shows empty, bit 14 shows full (1024 held) and bit 15 shows half full (512 or more held). `host_wr_ready` is low whenever the FIFO is full.
- R4: A scan updates each channel whose bit is set in the enable mask, in ascending order, from successive FIFO samples. Channels whose bit is clear keep their value. Busy (bit 1) is high while the scan runs, one channel per clock.
- R5: Trigger source bits 4:2 use this encoding:
  - 0: none.
  - 1: a host read of address 1.
  - 2: rising edge of `ext_trig`.
  - 3: falling edge of `ext_trig`.
  - 4, 5, 6: rising edge of `tmr_in[0]`, `tmr_in[1]`, `tmr_in[2]`.

  The pin and timer inputs pass a two-flop synchronizer before edge detection.
- R6: An event from a source that is not selected, a trigger with source 0, a trigger outside FIFO mode, and a trigger while busy all start no scan.
- R7: When a scan reaches an enabled channel and the FIFO is empty, bit 5 latches to 1 and that channel keeps its value. The latch holds until a control write with bit 5 = 1 clears it. If a new underrun happens in the same cycle as the clear, the new underrun wins.
- R8: A control write with bit 12 = 1 empties the FIFO. Bit 12 always reads 0.
- R9: With bit 7 set, each popped sample is written back to the tail in the same cycle. The FIFO count does not change, the loaded pattern repeats across scans, and `host_wr_ready` is low in that cycle.
- R10: `irq` is the interrupt condition selected by bits 11:9, gated by FIFO mode:
  - 0: empty.
  - 1: not empty.
  - 2: not half full.
  - 3: half full.
  - 4: not full.
  - 5: full.
  - 6 and 7: never.

  Outside FIFO mode `irq` is 0.
- R11: Bits 0, 4:2, 7, 8 and 11:9 read back as written, and `bipolar` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_wr | input | 1 | host write strobe |
| host_rd | input | 1 | host read strobe |
| host_addr | input | ADDR_W | register word address |
| host_wdata | input | BUS_W | write data |
| host_rdata | output | BUS_W | read data for `host_addr` |
| host_wr_ready | output | 1 | data-port write will be accepted |
| fifo_allow | input | 1 | global permission for FIFO mode |
| ext_trig | input | 1 | asynchronous external trigger pin |
| tmr_in | input | NTMR | asynchronous timer outputs |
| dac_out | output | NCH*SAMPLE_W | channel outputs, channel n in bits n*SAMPLE_W upward |
| bipolar | output | 1 | selected output range |
| irq | output | 1 | FIFO-level interrupt |

## Verification
The assertions check on every cycle that:
- ready never shows while the FIFO is full;
- the count never exceeds its depth;
- a pop never happens on an empty FIFO;
- underrun stays latched until it is cleared;
- a wraparound re-queue leaves the count unchanged;
- `irq` stays low outside FIFO mode;
- a scan covers more than one clock.

Some behaviour only the bench scenarios can show. These are:
- which sample reaches which channel;
- how each trigger source is selected, and that the wrong edge or source is ignored;
- that the wraparound pattern repeats;
- the direct-mode path;
- the half-full and full thresholds at exactly 512 and 1024.

The bench mixes these directed cases with random scans checked against a queue model.

// File: rtl/dac_scan_pkg.sv
package dac_scan_pkg;

  typedef enum logic [2:0] {
    TRG_NONE = 3'd0, TRG_SOFT = 3'd1, TRG_PIN_RISE = 3'd2, TRG_PIN_FALL = 3'd3,
    TRG_TMR0 = 3'd4, TRG_TMR1 = 3'd5, TRG_TMR2 = 3'd6, TRG_RSVD = 3'd7
  } trig_sel_e;

  typedef enum logic [2:0] {
    IRQ_EMPTY = 3'd0, IRQ_NEMPTY = 3'd1, IRQ_NHALF = 3'd2, IRQ_HALF = 3'd3,
    IRQ_NFULL = 3'd4, IRQ_FULL = 3'd5, IRQ_OFF6 = 3'd6, IRQ_OFF7 = 3'd7
  } irq_sel_e;

  typedef struct packed {
    irq_sel_e  irq_sel;
    logic      fifo_en;
    logic      wrap;
    trig_sel_e trig;
    logic      bipolar;
  } ctrl_t;

  // register word addresses
  localparam int REG_CTRL   = 0;
  localparam int REG_DATA   = 1;
  localparam int REG_CHEN   = 2;
  localparam int REG_DIRECT = 3;

  // control/status bit positions
  localparam int CB_RANGE = 0;
  localparam int CB_BUSY  = 1;
  localparam int CB_TRIG  = 2;
  localparam int CB_UNDER = 5;
  localparam int CB_WRAP  = 7;
  localparam int CB_FEN   = 8;
  localparam int CB_IRQ   = 9;
  localparam int CB_FRST  = 12;
  localparam int CB_EMPTY = 13;
  localparam int CB_FULL  = 14;
  localparam int CB_HALF  = 15;

  function automatic logic irq_level(irq_sel_e s, logic e, logic f, logic h);
    case (s)
      IRQ_EMPTY:  return e;
      IRQ_NEMPTY: return !e;
      IRQ_NHALF:  return !h;
      IRQ_HALF:   return h;
      IRQ_NFULL:  return !f;
      IRQ_FULL:   return f;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          half
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign half     = (count >= CW'(DEPTH / 2));
  assign do_pop   = pop & ~empty;
  assign do_push  = push & (~full | do_pop);
  assign pop_data = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dac_trig_unit.sv
module dac_trig_unit
  import dac_scan_pkg::*;
#(
  parameter int NTMR = 3,
  parameter int SYNC = 2,
  localparam int NIN = NTMR + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_pin,
  input  logic [NTMR-1:0] tmr,
  input  logic            sw_req,
  input  trig_sel_e       sel,
  input  logic            arm,
  output logic            trig_pulse
);
  logic [NIN-1:0] raw, rise, fall;
  logic           hit;

  assign raw = {tmr, ext_pin};

  for (genvar i = 0; i < NIN; i++) begin : g_in
    logic [SYNC-1:0] chain;
    logic            last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[SYNC-2:0], raw[i]};
        last  <= chain[SYNC-1];
      end
    end
    assign rise[i] = chain[SYNC-1] & ~last;
    assign fall[i] = ~chain[SYNC-1] & last;
  end

  always_comb begin
    hit = 1'b0;
    if (sel == TRG_SOFT)          hit = sw_req;
    else if (sel == TRG_PIN_RISE) hit = rise[0];
    else if (sel == TRG_PIN_FALL) hit = fall[0];
    else begin
      for (int t = 0; t < NTMR; t++) begin
        if (int'(sel) == int'(TRG_TMR0) + t) hit = rise[t+1];
      end
    end
  end

  assign trig_pulse = arm & hit;
endmodule

// File: rtl/dac_scan_seq.sv
module dac_scan_seq #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCH-1:0] chen,
  input  logic           wrap,
  input  logic           fifo_empty,
  output logic           busy,
  output logic [CW-1:0]  cur_ch,
  output logic           pop,
  output logic           requeue,
  output logic           underrun_evt
);
  logic cur_en;

  assign cur_en       = busy & chen[cur_ch];
  assign pop          = cur_en & ~fifo_empty;
  assign requeue      = pop & wrap;
  assign underrun_evt = cur_en & fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_ch <= '0;
    end else if (!busy) begin
      busy   <= start;
      cur_ch <= '0;
    end else if (cur_ch == CW'(NCH - 1)) begin
      busy   <= 1'b0;
    end else begin
      cur_ch <= cur_ch + 1'b1;
    end
  end
endmodule

// File: rtl/dac_scan_fifo.sv
module dac_scan_fifo
  import dac_scan_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 1024,
  parameter int NTMR     = 3,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 3,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PAD_W   = BUS_W - SAMPLE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [BUS_W-1:0]        host_wdata,
  output logic [BUS_W-1:0]        host_rdata,
  output logic                    host_wr_ready,
  input  logic                    fifo_allow,
  input  logic                    ext_trig,
  input  logic [NTMR-1:0]         tmr_in,
  output logic [NCH*SAMPLE_W-1:0] dac_out,
  output logic                    bipolar,
  output logic                    irq
);
  ctrl_t                ctrl_q;
  logic [NCH-1:0]       chen_q;
  logic                 underrun_q;
  logic [SAMPLE_W-1:0]  dac_q [NCH];

  logic fifo_active, wr_ctrl, wr_data, wr_chen, rd_swtrig;
  logic fifo_clr, push_host, fifo_push, fifo_empty, fifo_full, fifo_half;
  logic [SAMPLE_W-1:0] pop_data, push_data, host_sample;
  logic [CNT_W-1:0]    fifo_count;
  logic trig_pulse, busy, pop, requeue, underrun_evt;
  logic [CH_W-1:0] cur_ch;

  assign fifo_active   = fifo_allow & ctrl_q.fifo_en;
  assign wr_ctrl       = host_wr & (host_addr == ADDR_W'(REG_CTRL));
  assign wr_data       = host_wr & (host_addr == ADDR_W'(REG_DATA));
  assign wr_chen       = host_wr & (host_addr == ADDR_W'(REG_CHEN));
  assign rd_swtrig     = host_rd & (host_addr == ADDR_W'(REG_DATA));
  assign host_sample   = host_wdata[BUS_W-1 -: SAMPLE_W];
  assign host_wr_ready = ~fifo_full & ~requeue;
  assign push_host     = wr_data & fifo_active & host_wr_ready;
  assign fifo_clr      = wr_ctrl & host_wdata[CB_FRST];
  assign fifo_push     = push_host | requeue;
  assign push_data     = requeue ? pop_data : host_sample;

  dac_sample_fifo #(.DW(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .clr(fifo_clr), .push(fifo_push), .push_data,
    .pop, .pop_data, .count(fifo_count), .empty(fifo_empty),
    .full(fifo_full), .half(fifo_half)
  );

  dac_trig_unit #(.NTMR(NTMR), .SYNC(2)) u_trig (
    .clk, .rst_n, .ext_pin(ext_trig), .tmr(tmr_in), .sw_req(rd_swtrig),
    .sel(ctrl_q.trig), .arm(fifo_active & ~busy), .trig_pulse
  );

  dac_scan_seq #(.NCH(NCH)) u_seq (
    .clk, .rst_n, .start(trig_pulse), .chen(chen_q), .wrap(ctrl_q.wrap),
    .fifo_empty, .busy, .cur_ch, .pop, .requeue, .underrun_evt
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      chen_q     <= '0;
      underrun_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.bipolar <= host_wdata[CB_RANGE];
        ctrl_q.trig    <= trig_sel_e'(host_wdata[CB_TRIG +: 3]);
        ctrl_q.wrap    <= host_wdata[CB_WRAP];
        ctrl_q.fifo_en <= host_wdata[CB_FEN];
        ctrl_q.irq_sel <= irq_sel_e'(host_wdata[CB_IRQ +: 3]);
      end
      if (wr_chen) chen_q <= host_wdata[NCH-1:0];
      if (underrun_evt)                          underrun_q <= 1'b1;
      else if (wr_ctrl && host_wdata[CB_UNDER])  underrun_q <= 1'b0;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic wr_direct;
    assign wr_direct = host_wr & ~fifo_active & (host_addr == ADDR_W'(REG_DIRECT + ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              dac_q[ch] <= '0;
      else if (pop && cur_ch == CH_W'(ch))     dac_q[ch] <= pop_data;
      else if (wr_direct)                      dac_q[ch] <= host_sample;
    end
    assign dac_out[ch*SAMPLE_W +: SAMPLE_W] = dac_q[ch];
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(REG_CTRL)) begin
      host_rdata[CB_RANGE]     = ctrl_q.bipolar;
      host_rdata[CB_BUSY]      = busy;
      host_rdata[CB_TRIG +: 3] = ctrl_q.trig;
      host_rdata[CB_UNDER]     = underrun_q;
      host_rdata[CB_WRAP]      = ctrl_q.wrap;
      host_rdata[CB_FEN]       = ctrl_q.fifo_en;
      host_rdata[CB_IRQ +: 3]  = ctrl_q.irq_sel;
      host_rdata[CB_EMPTY]     = fifo_empty;
      host_rdata[CB_FULL]      = fifo_full;
      host_rdata[CB_HALF]      = fifo_half;
    end else if (host_addr == ADDR_W'(REG_CHEN)) begin
      host_rdata[NCH-1:0] = chen_q;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (host_addr == ADDR_W'(REG_DIRECT + ch)) host_rdata = {dac_q[ch], {PAD_W{1'b0}}};
      end
    end
  end

  assign bipolar = ctrl_q.bipolar;
  assign irq     = fifo_active & irq_level(ctrl_q.irq_sel, fifo_empty, fifo_full, fifo_half);
endmodule

// File: rtl/dac_scan_fifo_chk.sv
module dac_scan_fifo_chk #(
  parameter int NCH    = 2,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [BUS_W-1:0]  host_wdata,
  input logic              host_wr_ready,
  input logic              fifo_allow,
  input logic              fifo_en,
  input logic              irq,
  input logic              busy,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              underrun_q,
  input logic              pop,
  input logic              requeue
);
  logic ctrl_wr;
  assign ctrl_wr = host_wr && (host_addr == '0);

  assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !host_wr_ready);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  assert_scan_multi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (NCH > 1 && $rose(busy)) |=> busy);

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_q && !(ctrl_wr && host_wdata[5])) |=> underrun_q);

  assert_wrap_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (requeue && !(ctrl_wr && host_wdata[12])) |=> fifo_count == $past(fifo_count));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_allow && fifo_en) |-> !irq);
endmodule

bind dac_scan_fifo dac_scan_fifo_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_wr_ready(host_wr_ready), .fifo_allow(fifo_allow),
  .fifo_en(ctrl_q.fifo_en), .irq(irq), .busy(busy), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .fifo_count(fifo_count), .underrun_q(underrun_q),
  .pop(pop), .requeue(requeue)
);

// File: tb/dac_scan_fifo_tb.sv
module dac_scan_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_wr_ready;
  logic        fifo_allow = 1'b0, ext_trig = 1'b0;
  logic [2:0]  tmr_in = '0;
  logic [23:0] dac_out;
  logic        bipolar, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [11:0] mq[$];
  logic [11:0] e0 = '0, e1 = '0;

  always #2 clk = ~clk;

  dac_scan_fifo u_dut (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .host_wr_ready, .fifo_allow, .ext_trig, .tmr_in, .dac_out, .bipolar, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  function automatic logic [15:0] cw(input bit bip, input int trig, input bit wrap,
                                     input bit en, input int isel, input bit uclr, input bit frst);
    logic [15:0] v = '0;
    v[0] = bip; v[4:2] = 3'(trig); v[5] = uclr; v[7] = wrap; v[8] = en;
    v[11:9] = 3'(isel); v[12] = frst;
    return v;
  endfunction

  function automatic logic exp_irq(input int sel, input int n);
    case (sel)
      0: return n == 0;
      1: return n != 0;
      2: return n < 512;
      3: return n >= 512;
      4: return n < 1024;
      5: return n == 1024;
      default: return 1'b0;
    endcase
  endfunction

  task automatic push(input logic [11:0] s);
    wr(3'd1, {s, 4'($urandom_range(0, 15))});
    mq.push_back(s);
  endtask

  task automatic swtrig();
    logic [15:0] d;
    rd(3'd1, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v);
    chk("R1 ctrl", v, 16'h2000);
    chk("R1 dac", dac_out, 24'h0);
    chk("R1 irq/bip", {irq, bipolar}, 2'b00);

    // R2 direct mode, low nibble dropped (R3 style field)
    wr(3'd3, 16'hABC5);
    chk("R2 direct ch0", dac_out[11:0], 12'hABC);
    wr(3'd4, 16'h1237);
    chk("R2 direct ch1", dac_out[23:12], 12'h123);
    e0 = 12'hABC; e1 = 12'h123;
    fifo_allow = 1'b1;
    wr(3'd1, 16'h5550);           // en bit 0: data port not stored
    wr(3'd0, cw(0, 1, 0, 1, 0, 0, 0));
    rd(3'd0, v);
    chk("R2 data ignored in direct mode", v[13], 1'b1);
    chk("R10 irq empty sel", irq, exp_irq(0, 0));
    wr(3'd3, 16'hFFF0);
    chk("R2 direct ignored in fifo mode", dac_out[11:0], e0);

    // R4/R3 scan with sw trigger
    wr(3'd2, 16'h0003);
    push(12'h111); push(12'h222); push(12'h333);
    rd(3'd1, v);
    rd(3'd0, v);
    chk("R4 busy during scan", v[1], 1'b1);
    settle();
    rd(3'd0, v);
    chk("R4 busy cleared", v[1], 1'b0);
    chk("R4 scan outputs", dac_out, {12'h222, 12'h111});
    void'(mq.pop_front()); void'(mq.pop_front());
    // R7 underrun: one sample, two channels
    swtrig();
    void'(mq.pop_front());
    chk("R7 partial scan", dac_out, {12'h222, 12'h333});
    rd(3'd0, v);
    chk("R7 underrun latched", v[5], 1'b1);
    wr(3'd0, cw(0, 1, 0, 1, 0, 1, 0));
    rd(3'd0, v);
    chk("R7 underrun cleared", v[5], 1'b0);
    chk("R8 bit12 reads 0", v[12], 1'b0);

    // R4 channel skip
    wr(3'd2, 16'h0002);
    push(12'h444);
    swtrig(); void'(mq.pop_front());
    chk("R4 ch1 only", dac_out, {12'h444, 12'h333});
    e0 = 12'h333; e1 = 12'h444;

    // R6 source none
    wr(3'd0, cw(0, 0, 0, 1, 0, 0, 0));
    wr(3'd2, 16'h0003);
    push(12'h555); push(12'h666);
    swtrig();
    chk("R6 trig none", dac_out, {e1, e0});

    // R5 ext rising, R6 falling ignored, R5 falling
    wr(3'd0, cw(0, 2, 0, 1, 0, 0, 0));
    @(negedge clk) ext_trig = 1'b1; settle();
    chk("R5 ext rise", dac_out, {12'h666, 12'h555});
    void'(mq.pop_front()); void'(mq.pop_front());
    push(12'h777); push(12'h888);
    @(negedge clk) ext_trig = 1'b0; settle();
    chk("R6 fall ignored when rise selected", dac_out, {12'h666, 12'h555});
    wr(3'd0, cw(0, 3, 0, 1, 0, 0, 0));
    @(negedge clk) ext_trig = 1'b1; settle();
    @(negedge clk) ext_trig = 1'b0; settle();
    chk("R5 ext fall", dac_out, {12'h888, 12'h777});
    void'(mq.pop_front()); void'(mq.pop_front());

    // R5 timer 1, R6 timer 0 ignored
    wr(3'd0, cw(0, 5, 0, 1, 0, 0, 0));
    push(12'h999); push(12'hAAA);
    @(negedge clk) tmr_in[0] = 1'b1; settle();
    chk("R6 other timer ignored", dac_out, {12'h888, 12'h777});
    @(negedge clk) tmr_in[1] = 1'b1; settle();
    chk("R5 timer1 rise", dac_out, {12'hAAA, 12'h999});
    void'(mq.pop_front()); void'(mq.pop_front());
    tmr_in = '0; settle();

    // R3 fill to full, R10 levels
    wr(3'd0, cw(0, 1, 0, 1, 3, 0, 1));
    mq.delete();
    for (int i = 0; i < 511; i++) wr(3'd1, 16'(i << 4));
    rd(3'd0, v);
    chk("R3 below half", v[15], 1'b0);
    chk("R10 half sel at 511", irq, exp_irq(3, 511));
    wr(3'd1, 16'h0000);
    rd(3'd0, v);
    chk("R3 half at 512", v[15], 1'b1);
    chk("R10 half sel at 512", irq, exp_irq(3, 512));
    for (int i = 512; i < 1024; i++) wr(3'd1, 16'h0010);
    rd(3'd0, v);
    chk("R3 full", v[15:13], 3'b110);
    chk("R3 ready low", host_wr_ready, 1'b0);
    wr(3'd0, cw(0, 1, 0, 1, 5, 0, 0));
    chk("R10 full sel", irq, exp_irq(5, 1024));
    wr(3'd0, cw(0, 1, 0, 1, 2, 0, 0));
    chk("R10 nhalf sel", irq, exp_irq(2, 1024));
    wr(3'd0, cw(0, 1, 0, 1, 6, 0, 0));
    chk("R10 sel 6 never", irq, 1'b0);
    fifo_allow = 1'b0; @(negedge clk);
    wr(3'd0, cw(0, 1, 0, 1, 5, 0, 0));
    chk("R10 gated off outside fifo mode", irq, 1'b0);
    fifo_allow = 1'b1;
    // R8 reset
    wr(3'd0, cw(0, 1, 0, 1, 0, 0, 1));
    rd(3'd0, v);
    chk("R8 fifo reset empties", v[15:13], 3'b001);

    // R9 wraparound
    wr(3'd0, cw(0, 1, 1, 1, 0, 0, 0));
    wr(3'd1, 16'hA010); wr(3'd1, 16'hB020); wr(3'd1, 16'hC030);
    swtrig(); chk("R9 wrap scan1", dac_out, {12'hB02, 12'hA01});
    swtrig(); chk("R9 wrap scan2", dac_out, {12'hA01, 12'hC03});
    swtrig(); chk("R9 wrap scan3", dac_out, {12'hC03, 12'hB02});
    rd(3'd0, v);
    chk("R9 no underrun, not empty", {v[5], v[13]}, 2'b00);

    // R11 field readback and range pin
    wr(3'd0, cw(1, 6, 1, 1, 4, 0, 1));
    rd(3'd0, v);
    chk("R11 readback", {v[11:7], v[4:2], v[0]}, {3'd4, 1'b1, 1'b1, 3'd6, 1'b1});
    chk("R11 bipolar pin", bipolar, 1'b1);

    // random scans against queue model (R4, R7)
    wr(3'd0, cw(0, 1, 0, 1, 0, 0, 1));
    mq.delete();
    e0 = dac_out[11:0]; e1 = dac_out[23:12];
    for (int it = 0; it < 40; it++) begin
      int n;
      logic [1:0] en;
      logic und;
      n  = $urandom_range(0, 4);
      en = 2'($urandom_range(1, 3));
      und = 1'b0;
      for (int k = 0; k < n; k++) push(12'($urandom));
      wr(3'd2, {14'h0, en});
      swtrig();
      if (en[0]) begin if (mq.size() > 0) e0 = mq.pop_front(); else und = 1'b1; end
      if (en[1]) begin if (mq.size() > 0) e1 = mq.pop_front(); else und = 1'b1; end
      chk("R4 random scan", dac_out, {e1, e0});
      rd(3'd0, v);
      chk("R7 random underrun", v[5], und);
      wr(3'd0, cw(0, 1, 0, 1, 0, 1, 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule